// File: doc/BRIEF.md
# Interprocessor Interrupt Controller

This block links a local processor to a remote one with interrupts. The local side reaches it through a small command port with four functions. A control write picks one of seven priority-interrupt channels, can drop a pending incoming interrupt, and can ask for an interrupt to be sent to the remote side. A status read returns the pending flag together with the selected channel. The two data functions exist but carry nothing.

While an incoming interrupt is pending and the channel is not zero, the block raises the request line for that channel. An outgoing interrupt leaves as a one-byte packet on a valid/ready byte port. The block then waits for a one-byte reply code and sorts it into acknowledge, failed interrupt or protocol error. How the packet is carried to the remote side is outside the block.

Top module: `ipi_ctrl`

## Requirements
- R1: A control write (`cmd_func` = 0) loads `cmd_wdata[2:0]` as the channel. A status read issued later shows the new channel. Data bits 5 and above have no effect.
- R2: A one-cycle pulse on `remote_irq` sets the pending flag. A status read (`cmd_func` = 1) raises `rd_valid` for one cycle after the command edge. `rd_data` then carries the pending flag in bit 3 and the channel in bits 2:0, and every other bit is zero.
- R3: A control write with bit 3 set clears the pending flag. If a `remote_irq` pulse arrives in the same cycle, the flag stays set.
- R4: `pi_req[n]` is high exactly when the flag is pending and the channel equals n. At most one bit is high. The lines change at the same clock edge as the state that drives them.
- R5: Channel 0 means interrupts are disabled. No request line is raised, although the pending flag is still kept and reported.
- R6: A control write with bit 4 set raises `tx_valid` after the command edge, with `tx_byte` = 6. Both hold unchanged until the edge where `tx_ready` is high.
- R7: Once the packet is accepted, the next `rx_valid` is taken as the reply. Code 3 gives a one-cycle `irq_ack`. Codes 4 and 5 give a one-cycle `irq_fail`. Any other code gives a one-cycle `proto_err`. The pulse follows the reply edge. A reply that arrives while nothing is outstanding is ignored.
- R8: A send command issued while a packet or reply is still outstanding is held back. The second packet is offered at the edge where the reply arrives. Several held-back commands merge into one packet.
- R9: A data read (`cmd_func` = 2) returns `rd_valid` with all-zero `rd_data`. A data write (`cmd_func` = 3) changes no state.
- R10: After reset, the channel, the pending flag, `pi_req`, `tx_valid` and all result pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_func | input | 2 | 0 control write, 1 status read, 2 data read, 3 data write |
| cmd_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | DATA_W | Read data |
| remote_irq | input | 1 | Incoming interrupt pulse from the remote side |
| pi_req | output | NUM_CH | Request line per channel (bit 0 unused) |
| tx_valid | output | 1 | Outgoing packet byte valid |
| tx_byte | output | 8 | Outgoing packet byte |
| tx_ready | input | 1 | Transport accepts the byte |
| rx_valid | input | 1 | Reply code valid |
| rx_code | input | 8 | Reply code |
| irq_ack | output | 1 | Remote acknowledged the interrupt |
| irq_fail | output | 1 | Remote reported error or timeout |
| proto_err | output | 1 | Reply code not recognised |

## Verification
If the pending flag or the channel register goes wrong, it shows on `pi_req` at the very next edge, because the request lines are registered from the next-state values. The same fault shows on the next status read one cycle later. If the link state goes wrong, either a packet never appears on `tx_valid` or a reply produces no pulse, and both are visible one cycle after the causing edge. Losing a held-back send is only visible when the reply to the first packet arrives: at that edge `tx_valid` fails to rise.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int OCTET_W = 8;

  typedef enum logic [1:0] {
    FN_CTRL_WR = 2'd0,
    FN_STAT_RD = 2'd1,
    FN_DATA_RD = 2'd2,
    FN_DATA_WR = 2'd3
  } ipi_func_e;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_SEND = 2'd1,
    LK_WAIT = 2'd2
  } link_state_e;

  localparam logic [OCTET_W-1:0] OPC_IRQ = 8'd6;
  localparam logic [OCTET_W-1:0] RSP_ACK = 8'd3;
  localparam logic [OCTET_W-1:0] RSP_ERR = 8'd4;
  localparam logic [OCTET_W-1:0] RSP_TMO = 8'd5;
endpackage

// File: rtl/ipi_chan_regs.sv
module ipi_chan_regs #(
  parameter int CHAN_W = 3,
  localparam int NUM_CH = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_clear,
  input  logic              set_pend,
  output logic [CHAN_W-1:0] chan_q,
  output logic              pend_q,
  output logic [NUM_CH-1:0] req_q
);
  logic [CHAN_W-1:0] chan_d;
  logic              pend_d;
  logic [NUM_CH-1:0] req_d;

  always_comb begin
    chan_d = wr_en ? wr_chan : chan_q;
    if (set_pend)
      pend_d = 1'b1;
    else if (wr_en && wr_clear)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  assign req_d[0] = 1'b0;
  for (genvar i = 1; i < NUM_CH; i++) begin : g_req
    assign req_d[i] = pend_d && (chan_d == CHAN_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      chan_q <= chan_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/ipi_link.sv
module ipi_link
  import ipi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               send_req,
  output logic               tx_valid,
  output logic [OCTET_W-1:0] tx_byte,
  input  logic               tx_ready,
  input  logic               rx_valid,
  input  logic [OCTET_W-1:0] rx_code,
  output logic               ack_q,
  output logic               fail_q,
  output logic               perr_q
);
  link_state_e state_q;
  logic        held_q;

  assign tx_valid = (state_q == LK_SEND);
  assign tx_byte  = (state_q == LK_SEND) ? OPC_IRQ : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_IDLE;
      held_q  <= 1'b0;
      ack_q   <= 1'b0;
      fail_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      fail_q <= 1'b0;
      perr_q <= 1'b0;
      case (state_q)
        LK_IDLE: begin
          if (send_req || held_q) begin
            state_q <= LK_SEND;
            held_q  <= 1'b0;
          end
        end
        LK_SEND: begin
          if (send_req) held_q <= 1'b1;
          if (tx_ready) state_q <= LK_WAIT;
        end
        LK_WAIT: begin
          if (send_req) held_q <= 1'b1;
          if (rx_valid) begin
            if (rx_code == RSP_ACK)
              ack_q <= 1'b1;
            else if (rx_code == RSP_ERR || rx_code == RSP_TMO)
              fail_q <= 1'b1;
            else
              perr_q <= 1'b1;
            if (send_req || held_q) begin
              state_q <= LK_SEND;
              held_q  <= 1'b0;
            end else begin
              state_q <= LK_IDLE;
            end
          end
        end
        default: state_q <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int DATA_W   = 36,
  parameter int CHAN_W   = 3,
  parameter int PEND_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic [CHAN_W-1:0] chan,
  input  logic              pend,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[CHAN_W-1:0] = chan;
    stat_word[PEND_BIT]   = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= stat_rd || data_rd;
      rd_data  <= stat_rd ? stat_word : '0;
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int DATA_W   = 36,
  parameter int CHAN_W   = 3,
  parameter int CLR_BIT  = 3,
  parameter int SEND_BIT = 4,
  localparam int NUM_CH  = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_func,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              remote_irq,
  output logic [NUM_CH-1:0] pi_req,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_code,
  output logic              irq_ack,
  output logic              irq_fail,
  output logic              proto_err
);
  logic              ctrl_wr, stat_rd, data_rd;
  logic [CHAN_W-1:0] chan_q;
  logic              pend_q;
  logic              unused_wbits;

  assign ctrl_wr = cmd_valid && (cmd_func == FN_CTRL_WR);
  assign stat_rd = cmd_valid && (cmd_func == FN_STAT_RD);
  assign data_rd = cmd_valid && (cmd_func == FN_DATA_RD);
  assign unused_wbits = ^cmd_wdata;

  ipi_chan_regs #(.CHAN_W(CHAN_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_wr),
    .wr_chan  (cmd_wdata[CHAN_W-1:0]),
    .wr_clear (cmd_wdata[CLR_BIT]),
    .set_pend (remote_irq),
    .chan_q   (chan_q),
    .pend_q   (pend_q),
    .req_q    (pi_req)
  );

  ipi_link u_link (
    .clk      (clk),
    .rst      (rst),
    .send_req (ctrl_wr && cmd_wdata[SEND_BIT]),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_code  (rx_code),
    .ack_q    (irq_ack),
    .fail_q   (irq_fail),
    .perr_q   (proto_err)
  );

  ipi_readback #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .PEND_BIT(CLR_BIT)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .chan     (chan_q),
    .pend     (pend_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
  parameter int DATA_W = 36,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_func,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              remote_irq,
  input logic              pend,
  input logic [NUM_CH-1:0] pi_req,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic              irq_ack,
  input logic              irq_fail,
  input logic              proto_err
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(pi_req)); // R4
  AST_NO_CH0_REQ: assert property (@(posedge clk) disable iff (rst) !pi_req[0]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) remote_irq |=> pend); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R6
  AST_TX_OPCODE: assert property (@(posedge clk) disable iff (rst) tx_valid |-> (tx_byte == 8'd6)); // R6
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $countones({irq_ack, irq_fail, proto_err}) <= 1); // R7
  AST_DRD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_func == 2'd2) |=> (rd_valid && rd_data == '0)); // R9
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
  .rd_valid(rd_valid), .rd_data(rd_data), .remote_irq(remote_irq),
  .pend(pend_q), .pi_req(pi_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .tx_ready(tx_ready), .irq_ack(irq_ack), .irq_fail(irq_fail),
  .proto_err(proto_err)
);

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
  localparam int DW = 36;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_func = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          remote_irq = 1'b0;
  logic [NC-1:0] pi_req;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_ready = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_code = '0;
  logic          irq_ack, irq_fail, proto_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_ctrl u_ipi_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .remote_irq(remote_irq), .pi_req(pi_req), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_code(rx_code), .irq_ack(irq_ack), .irq_fail(irq_fail),
    .proto_err(proto_err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_wr(input logic [DW-1:0] v);
    cmd_valid = 1'b1; cmd_func = 2'd0; cmd_wdata = v;
    step();
    cmd_valid = 1'b0; cmd_wdata = '0;
  endtask

  task automatic stat_rd(input string req, input logic [DW-1:0] exp);
    cmd_valid = 1'b1; cmd_func = 2'd1;
    step();
    cmd_valid = 1'b0;
    check(req, "rd_valid", rd_valid, 1);
    check(req, "status", rd_data, exp);
  endtask

  task automatic pulse_remote();
    remote_irq = 1'b1;
    step();
    remote_irq = 1'b0;
  endtask

  task automatic push_packet(input string req);
    check(req, "tx_valid", tx_valid, 1);
    check(req, "tx_byte", tx_byte, 8'd6);
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
  endtask

  task automatic reply(input string req, input logic [7:0] code,
                       input logic ea, input logic ef, input logic ep);
    rx_valid = 1'b1; rx_code = code;
    step();
    rx_valid = 1'b0;
    check(req, "irq_ack", irq_ack, ea);
    check(req, "irq_fail", irq_fail, ef);
    check(req, "proto_err", proto_err, ep);
  endtask

  task automatic t_reset();
    check("R10", "pi_req", pi_req, 0);
    check("R10", "tx_valid", tx_valid, 0);
    check("R10", "results", {irq_ack, irq_fail, proto_err}, 0);
    stat_rd("R10", 0);
  endtask

  task automatic t_channel();
    ctrl_wr(36'hFFFF_FFE5);
    stat_rd("R1", 5);
    ctrl_wr(36'h2);
    stat_rd("R1", 2);
    check("R5", "no pend no req", pi_req, 0);
  endtask

  task automatic t_pending();
    ctrl_wr(36'h5);
    pulse_remote();
    check("R4", "req ch5", pi_req, 8'h20);
    stat_rd("R2", 36'hD);
    ctrl_wr(36'h3);
    check("R4", "req moves ch3", pi_req, 8'h08);
    ctrl_wr(36'hB);
    check("R3", "clear drops req", pi_req, 0);
    stat_rd("R3", 36'h3);
  endtask

  task automatic t_set_wins();
    cmd_valid = 1'b1; cmd_func = 2'd0; cmd_wdata = 36'h9;
    remote_irq = 1'b1;
    step();
    cmd_valid = 1'b0; remote_irq = 1'b0;
    check("R3", "set wins req", pi_req, 8'h02);
    stat_rd("R3", 36'h9);
  endtask

  task automatic t_chan_zero();
    ctrl_wr(36'h0);
    check("R5", "ch0 no req", pi_req, 0);
    stat_rd("R5", 36'h8);
    ctrl_wr(36'h8);
    stat_rd("R5", 36'h0);
  endtask

  task automatic t_send();
    ctrl_wr(36'h14);
    check("R6", "tx_valid", tx_valid, 1);
    check("R6", "tx_byte", tx_byte, 8'd6);
    step();
    check("R6", "tx held", tx_valid, 1);
    stat_rd("R1", 36'h4);
    push_packet("R6");
    check("R6", "tx dropped", tx_valid, 0);
    reply("R7", 8'd3, 1, 0, 0);
    step();
    check("R7", "ack one cycle", irq_ack, 0);
  endtask

  task automatic t_codes();
    ctrl_wr(36'h10); push_packet("R7"); reply("R7", 8'd4, 0, 1, 0);
    ctrl_wr(36'h10); push_packet("R7"); reply("R7", 8'd5, 0, 1, 0);
    ctrl_wr(36'h10); push_packet("R7"); reply("R7", 8'd9, 0, 0, 1);
    check("R7", "idle after", tx_valid, 0);
    reply("R7", 8'd3, 0, 0, 0);
  endtask

  task automatic t_queue();
    ctrl_wr(36'h10);
    push_packet("R8");
    ctrl_wr(36'h10);
    ctrl_wr(36'h10);
    check("R8", "held off", tx_valid, 0);
    reply("R8", 8'd3, 1, 0, 0);
    check("R8", "second packet", tx_valid, 1);
    push_packet("R8");
    reply("R8", 8'd3, 1, 0, 0);
    step();
    check("R8", "merged", tx_valid, 0);
  endtask

  task automatic t_data();
    ctrl_wr(36'h6);
    pulse_remote();
    cmd_valid = 1'b1; cmd_func = 2'd2;
    step();
    cmd_valid = 1'b0;
    check("R9", "drd valid", rd_valid, 1);
    check("R9", "drd zero", rd_data, 0);
    cmd_valid = 1'b1; cmd_func = 2'd3; cmd_wdata = 36'h1F;
    step();
    cmd_valid = 1'b0; cmd_wdata = '0;
    check("R9", "dwr no tx", tx_valid, 0);
    check("R9", "dwr req kept", pi_req, 8'h40);
    stat_rd("R9", 36'hE);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_channel();
    t_pending();
    t_set_wins();
    t_chan_zero();
    t_send();
    t_codes();
    t_queue();
    t_data();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule